// File: doc/BRIEF.md
# Reversible Two's-Complement Adder/Subtractor

This block adds or subtracts two N-bit operands. It is built only from modelled reversible gates, each of which has as many outputs as inputs. The controlled-NOT gate maps (a, b) to (a, a^b). The three-line gate with half-adder behaviour maps (a, b, c) to (a, a^b, (a&b)^c). Every bit position is one stage. A stage first XORs the mode line onto its Y bit, so Y passes through as it is for addition and is inverted for subtraction. Two cascaded three-line gates then form a full adder. The mode line leaves each stage as a copy and enters the next, so it never fans out. Each carry ripples upward in the same way.

The carry into bit 0 comes from XORing the mode line onto a zero ancilla. This gives X + ~Y + 1 when subtracting. A controlled-NOT copies the carry into the top stage onto a second ancilla, and a further controlled-NOT XORs that copy with the final carry to form the signed overflow flag. The result, the carry, the flag, the mode copy and every garbage line are all outputs. The ancillas are all inputs. As a result, the whole 3N+3-bit mapping is a bijection.

Top module: `rev_addsub`

## Requirements
- R1: With sub_i=0 and all ancilla inputs at 0, res_o equals (x_i + y_i) mod 2^N.
- R2: With sub_i=1 and all ancilla inputs at 0, res_o equals (x_i - y_i) mod 2^N.
- R3: With all ancillas at 0, cout_o is bit N of x_i + (y_i XOR {N{sub_i}}) + sub_i. This is the unsigned carry for addition, and it is 1 for subtraction exactly when x_i >= y_i (no borrow).
- R4: With all ancillas at 0, ovf_o is 1 exactly when the signed two's-complement sum or difference lies outside [-2^(N-1), 2^(N-1)-1].
- R5: ctl_o always equals sub_i, because the mode copy passes through every stage.
- R6: gx_o always equals x_i bit for bit.
- R7: gp_o[i] always equals x_i[i] ^ y_i[i] ^ sub_i.
- R8: The map from the input vector {anc_i, y_i, x_i, anc_ovf_i, anc_cin_i, sub_i} to the output vector {ctl_o, gx_o, gp_o, res_o, cout_o, ovf_o} is injective over all 2^(3N+3) values.
- R9: With sub_i=0 and anc_i=0, setting anc_ovf_i=1 inverts ovf_o and leaves res_o and cout_o unchanged.
- R10: With sub_i=0, anc_ovf_i=0 and anc_i=0, setting anc_cin_i=1 makes {cout_o, res_o} equal x_i + y_i + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sub_i | input | 1 | Mode: 0 add, 1 subtract |
| anc_cin_i | input | 1 | Ancilla that becomes the bit-0 carry-in (0 in normal use) |
| anc_ovf_i | input | 1 | Ancilla that holds the copy of the top carry-in (0 in normal use) |
| x_i | input | N | Operand X |
| y_i | input | N | Operand Y |
| anc_i | input | N | Per-stage ancillas for the first gate's target (0 in normal use) |
| ctl_o | output | 1 | Mode copy leaving the top stage |
| gx_o | output | N | Garbage: pass-through copy of X |
| gp_o | output | N | Garbage: X ^ Y ^ mode, per bit |
| res_o | output | N | Sum or difference |
| cout_o | output | 1 | Carry out of the top stage |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The arithmetic assertions hold only when every ancilla input is zero, so each one is conditioned on that. The bench sweeps every operand pair in both modes with the ancillas at zero. Two further sweeps set only anc_cin_i or only anc_ovf_i. The bijectivity sweep drives every ancilla pattern, and only the structural assertions (mode copy, X copy, propagate line) are left active for it.

// File: rtl/rev_pkg.sv
package rev_pkg;
  localparam int unsigned QC_CNOT  = 1;
  localparam int unsigned QC_PERES = 4;

  // Gate count of the plain n-bit chain: per stage 1 CNOT + 2 Peres, plus LSB CNOT.
  function automatic int unsigned gates_plain(input int unsigned n);
    return 3 * n + 1;
  endfunction

  function automatic int unsigned garbage_plain(input int unsigned n);
    return 2 * n + 1;
  endfunction

  function automatic int unsigned qcost_plain(input int unsigned n);
    return n * (QC_CNOT + 2 * QC_PERES) + QC_CNOT;
  endfunction
endpackage

// File: rtl/rev_cnot.sv
module rev_cnot (
  input  logic a_i,
  input  logic b_i,
  output logic a_o,
  output logic b_o
);
  assign a_o = a_i;
  assign b_o = a_i ^ b_i;
endmodule

// File: rtl/rev_peres.sv
module rev_peres (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic a_o,
  output logic b_o,
  output logic c_o
);
  assign a_o = a_i;
  assign b_o = a_i ^ b_i;
  assign c_o = (a_i & b_i) ^ c_i;
endmodule

// File: rtl/rev_addsub_stage.sv
module rev_addsub_stage (
  input  logic ctl_i,
  input  logic x_i,
  input  logic y_i,
  input  logic cin_i,
  input  logic anc_i,
  output logic ctl_o,
  output logic gx_o,
  output logic gp_o,
  output logic s_o,
  output logic cout_o
);
  logic y_eff;
  logic p_w;
  logic g_w;

  rev_cnot u_inv (
    .a_i(ctl_i), .b_i(y_i),
    .a_o(ctl_o), .b_o(y_eff)
  );

  rev_peres u_half0 (
    .a_i(x_i), .b_i(y_eff), .c_i(anc_i),
    .a_o(gx_o), .b_o(p_w), .c_o(g_w)
  );

  rev_peres u_half1 (
    .a_i(p_w), .b_i(cin_i), .c_i(g_w),
    .a_o(gp_o), .b_o(s_o), .c_o(cout_o)
  );
endmodule

// File: rtl/rev_addsub.sv
module rev_addsub #(
  parameter int unsigned N = 4
) (
  input  logic         sub_i,
  input  logic         anc_cin_i,
  input  logic         anc_ovf_i,
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic [N-1:0] anc_i,
  output logic         ctl_o,
  output logic [N-1:0] gx_o,
  output logic [N-1:0] gp_o,
  output logic [N-1:0] res_o,
  output logic         cout_o,
  output logic         ovf_o
);
  import rev_pkg::*;

  localparam int unsigned GARBAGE_W = garbage_plain(N);
  localparam int unsigned LINES_W   = 3 * N + 3;

  logic [N:0]           ctl_chain;
  logic [N:0]           carry;
  logic [N-1:0]         stage_cin;
  logic                 msb_cin;
  logic                 cin_copy;
  logic [GARBAGE_W-1:0] garbage;
  logic [N-1:0]         gx_w;
  logic [N-1:0]         gp_w;
  logic [LINES_W-1:0]   out_lines;

  // LSB carry-in: mode line XORed onto a zero ancilla.
  rev_cnot u_lsb (
    .a_i(sub_i), .b_i(anc_cin_i),
    .a_o(ctl_chain[0]), .b_o(carry[0])
  );

  // Copy the carry entering the top stage onto the overflow ancilla.
  rev_cnot u_ovf_copy (
    .a_i(carry[N-1]), .b_i(anc_ovf_i),
    .a_o(msb_cin), .b_o(cin_copy)
  );

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i == N - 1) begin : g_top
      assign stage_cin[i] = msb_cin;
    end else begin : g_low
      assign stage_cin[i] = carry[i];
    end

    rev_addsub_stage u_stage (
      .ctl_i (ctl_chain[i]),
      .x_i   (x_i[i]),
      .y_i   (y_i[i]),
      .cin_i (stage_cin[i]),
      .anc_i (anc_i[i]),
      .ctl_o (ctl_chain[i+1]),
      .gx_o  (gx_w[i]),
      .gp_o  (gp_w[i]),
      .s_o   (res_o[i]),
      .cout_o(carry[i+1])
    );
  end

  // Overflow: top carry-out XORed onto the copied top carry-in.
  rev_cnot u_ovf_xor (
    .a_i(carry[N]), .b_i(cin_copy),
    .a_o(cout_o), .b_o(ovf_o)
  );

  assign garbage   = {ctl_chain[N], gx_w, gp_w};
  assign out_lines = {garbage, res_o, cout_o, ovf_o};
  assign ctl_o     = out_lines[LINES_W-1];
  assign gx_o      = out_lines[LINES_W-2 -: N];
  assign gp_o      = out_lines[LINES_W-2-N -: N];
endmodule

// File: rtl/rev_addsub_chk.sv
module rev_addsub_chk #(
  parameter int unsigned N = 4
) (
  input logic         sub_i,
  input logic         anc_cin_i,
  input logic         anc_ovf_i,
  input logic [N-1:0] x_i,
  input logic [N-1:0] y_i,
  input logic [N-1:0] anc_i,
  input logic         ctl_o,
  input logic [N-1:0] gx_o,
  input logic [N-1:0] gp_o,
  input logic [N-1:0] res_o,
  input logic         cout_o,
  input logic         ovf_o
);
  logic [N-1:0] y_eff;
  logic [N:0]   wide;
  logic         quiet;
  logic         known;

  always_comb begin
    y_eff = y_i ^ {N{sub_i}};
    wide  = {1'b0, x_i} + {1'b0, y_eff} + {{N{1'b0}}, sub_i};
    quiet = !anc_cin_i && !anc_ovf_i && (anc_i == '0);
    known = !$isunknown({sub_i, anc_cin_i, anc_ovf_i, x_i, y_i, anc_i});
    if (known) begin
      // R5
      ctl_copy_chk: assert (ctl_o == sub_i) else $error("mode copy mismatch");
      // R6
      x_copy_chk: assert (gx_o == x_i) else $error("X copy mismatch");
      // R7
      prop_line_chk: assert (gp_o == (x_i ^ y_eff)) else $error("propagate line mismatch");
      if (quiet) begin
        // R1 R2
        result_chk: assert (res_o == wide[N-1:0]) else $error("result mismatch");
        // R3
        carry_chk: assert (cout_o == wide[N]) else $error("carry mismatch");
        // R4
        no_overflow_chk: assert (ovf_o == ((x_i[N-1] == y_eff[N-1]) && (res_o[N-1] != x_i[N-1])))
          else $error("overflow flag mismatch");
      end
    end
  end
endmodule

bind rev_addsub rev_addsub_chk #(.N(N)) u_chk (.*);

// File: tb/rev_addsub_tb.sv
module rev_addsub_tb;
  localparam int N     = 4;
  localparam int IN_W  = 3 * N + 3;
  localparam int SPACE = 1 << IN_W;

  logic clk;
  logic rst_n;
  logic         sub_i, anc_cin_i, anc_ovf_i;
  logic [N-1:0] x_i, y_i, anc_i;
  logic         ctl_o, cout_o, ovf_o;
  logic [N-1:0] gx_o, gp_o, res_o;

  int checks;
  int errors;
  bit seen [SPACE];

  rev_addsub #(.N(N)) u_dut (
    .sub_i(sub_i), .anc_cin_i(anc_cin_i), .anc_ovf_i(anc_ovf_i),
    .x_i(x_i), .y_i(y_i), .anc_i(anc_i),
    .ctl_o(ctl_o), .gx_o(gx_o), .gp_o(gp_o), .res_o(res_o),
    .cout_o(cout_o), .ovf_o(ovf_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d (sub=%0b x=%0d y=%0d)", req, got, exp, sub_i, x_i, y_i);
    end
  endtask

  task automatic apply(input int v);
    @(posedge clk);
    sub_i     = v[0];
    anc_cin_i = v[1];
    anc_ovf_i = v[2];
    x_i       = v[3 +: N];
    y_i       = v[3+N +: N];
    anc_i     = v[3+2*N +: N];
    @(negedge clk);
  endtask

  function automatic int sval(input int u);
    return (u >= (1 << (N-1))) ? u - (1 << N) : u;
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int full, sres, exp_res, exp_c, exp_v, collisions;
    checks = 0; errors = 0;
    rst_n = 1'b0;
    sub_i = 0; anc_cin_i = 0; anc_ovf_i = 0; x_i = '0; y_i = '0; anc_i = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: all inputs zero give all outputs zero.
    check("R1 idle res", int'(res_o), 0);
    check("R3 idle cout", int'(cout_o), 0);
    check("R4 idle ovf", int'(ovf_o), 0);

    // R1 R2 R3 R4 R5 R6 R7: exhaustive operands, both modes, ancillas zero.
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++) begin
          apply(m | (a << 3) | (b << (3+N)));
          full    = (m == 0) ? a + b : a + ((~b) & ((1 << N) - 1)) + 1;
          exp_res = full & ((1 << N) - 1);
          exp_c   = (full >> N) & 1;
          sres    = (m == 0) ? sval(a) + sval(b) : sval(a) - sval(b);
          exp_v   = (sres < -(1 << (N-1)) || sres > (1 << (N-1)) - 1) ? 1 : 0;
          check(m ? "R2 difference" : "R1 sum", int'(res_o), exp_res);
          check("R3 carry", int'(cout_o), exp_c);
          check("R4 overflow", int'(ovf_o), exp_v);
          check("R5 mode copy", int'(ctl_o), m);
          check("R6 x copy", int'(gx_o), a);
          check("R7 propagate", int'(gp_o), a ^ b ^ (m ? (1 << N) - 1 : 0));
        end

    // R10: ancilla carry-in set in add mode adds one.
    for (int a = 0; a < (1 << N); a++)
      for (int b = 0; b < (1 << N); b++) begin
        apply(2 | (a << 3) | (b << (3+N)));
        check("R10 carry-in ancilla", int'({cout_o, res_o}), a + b + 1);
      end

    // R9: overflow ancilla inverts the flag only.
    for (int a = 0; a < (1 << N); a++)
      for (int b = 0; b < (1 << N); b++) begin
        apply(4 | (a << 3) | (b << (3+N)));
        sres  = sval(a) + sval(b);
        exp_v = (sres < -(1 << (N-1)) || sres > (1 << (N-1)) - 1) ? 1 : 0;
        check("R9 flag inverted", int'(ovf_o), 1 - exp_v);
        check("R9 result kept", int'({cout_o, res_o}), a + b);
      end

    // R8: every input vector maps to a distinct output vector.
    collisions = 0;
    for (int v = 0; v < SPACE; v++) begin
      int key;
      apply(v);
      key = int'({ctl_o, gx_o, gp_o, res_o, cout_o, ovf_o});
      if (seen[key]) collisions++;
      seen[key] = 1'b1;
    end
    check("R8 distinct outputs (collisions)", collisions, 0);

    finish_run();
  end
endmodule